// File: doc/BRIEF.md
# Flash Identification and Sector Mapper

This block sits between a host and a 16-bit NOR flash bus. A single start pulse makes it enter the flash's identification mode with a three-write unlock sequence. It then reads three code words: vendor, device and extended device. After that it leaves identification mode with a second three-write sequence. The codes pick one of two boot-block sector organizations. Both organizations fill a 2 MB bank. The host learns the organization and the number of sectors from held outputs.

Once the part is classified, the block walks the chosen organization. It streams the start byte address and index of every sector, one per clock cycle, beginning at the bank base and rising through the bank. If the vendor code is not the expected one, the block raises a flag and streams nothing.

The flash bus is a plain word-access handshake. A write or read strobe is held, with its word address and write data, until the flash returns ready. Read data is taken in the same cycle as ready.

Top module: `flash_id_mapper`

## Requirements
- R1: After start, the first three bus accesses are writes, in this order: 0x00AA to word address 0x555, then 0x0055 to word address 0xAAA, then 0x0090 to word address 0x555.
- R2: The next three accesses are reads, from word addresses 0, 1 and 3 in that order. The data they return are taken as the vendor, device and extended device codes.
- R3: The last three accesses are writes: 0x00AA to 0x555, then 0x0055 to 0xAAA, then 0x00F0 to 0x555. A run makes exactly nine accesses.
- R4: Only one access is in flight at a time. The write and read strobes are never high together. Strobe, address and write data are held unchanged until the cycle in which fb_ack is high.
- R5: Organization B (org_b=1) is chosen only when the device code equals 0x00C0 and the extended code equals 0x00C8. Any other pair gives organization A (org_b=0).
- R6: Organization A streams 40 sectors: 8 of 8 KB, then 2 of 32 KB, then 30 of 64 KB. Sector start addresses accumulate from the bank base 0x0100_0000, and sector_count reads 40.
- R7: Organization B streams 39 sectors: 8 of 8 KB, then 31 of 64 KB. Addresses accumulate from the same base, and sector_count reads 39.
- R8: The stream is valid on consecutive cycles with no gap. The index starts at 0 and rises by one each cycle. sec_last is high only on the final sector.
- R9: org_b, sector_count and unknown_vendor are updated once per run, before the stream. They then hold their values until a later run updates them.
- R10: If the vendor code is not 0x001F, unknown_vendor is set, sector_count reads 0, and no sector is streamed. The run still ends with done.
- R11: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse. A start while busy is ignored and causes no extra bus access.
- R12: After reset, the strobes, busy, done, sec_valid, sec_last, org_b, unknown_vendor and sector_count are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to identify and map the flash |
| fb_wr | output | 1 | Flash write strobe, held until fb_ack |
| fb_rd | output | 1 | Flash read strobe, held until fb_ack |
| fb_addr | output | 20 | Flash word address |
| fb_wdata | output | 16 | Flash write data |
| fb_rdata | input | 16 | Flash read data, valid with fb_ack |
| fb_ack | input | 1 | Flash ready: completes the current access |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| unknown_vendor | output | 1 | Vendor code did not match |
| org_b | output | 1 | Organization B was selected |
| sector_count | output | 6 | Number of sectors in the selected organization |
| sec_valid | output | 1 | A sector entry is present on the stream |
| sec_idx | output | 6 | Sector index |
| sec_addr | output | 32 | Sector start byte address |
| sec_last | output | 1 | Final sector of the stream |

## Verification
The bench models a flash that only answers with its codes once the full unlock sequence has been written. A sequencer that swapped an address, data value or step would therefore read erased data, and the vendor or organization outcome would change visibly.

The case with a matching device code but a wrong extended code targets a classifier that tests only one of the two codes; such a design would wrongly stream 39 sectors.

Each streamed address is compared against a bench-computed region sum. This catches an accumulator that adds the 32 KB size in organization B or misplaces a region boundary.

Further cases cover several ready latencies, a second start during a run, and a vendor mismatch. These catch strobes dropped before ready, a restarted sequence, and a stream emitted for an unknown part.

// File: rtl/fid_pkg.sv
package fid_pkg;

  localparam int STEP_W    = 4;
  localparam int STEP_LAST = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEQ   = 3'd1,
    ST_CLASS = 3'd2,
    ST_WALK  = 3'd3,
    ST_FIN   = 3'd4
  } fid_state_e;

  // Steps 3..5 are the identification reads, all others are writes.
  function automatic logic step_is_read(input logic [STEP_W-1:0] s);
    return (s == 4'd3) || (s == 4'd4) || (s == 4'd5);
  endfunction

  function automatic logic [11:0] step_addr(input logic [STEP_W-1:0] s);
    case (s)
      4'd1, 4'd7: return 12'hAAA;
      4'd3:       return 12'h000;
      4'd4:       return 12'h001;
      4'd5:       return 12'h003;
      default:    return 12'h555;
    endcase
  endfunction

  function automatic logic [7:0] step_data(input logic [STEP_W-1:0] s);
    case (s)
      4'd0, 4'd6: return 8'hAA;
      4'd1, 4'd7: return 8'h55;
      4'd2:       return 8'h90;
      4'd8:       return 8'hF0;
      default:    return 8'h00;
    endcase
  endfunction

  // Which code register a read step fills: 0 vendor, 1 device, 2 extended.
  function automatic logic [1:0] read_slot(input logic [STEP_W-1:0] s);
    logic [STEP_W-1:0] d;
    d = s - 4'd3;
    return d[1:0];
  endfunction

  // Size in KB of sector idx for the selected organization.
  function automatic int unsigned sector_kb(input logic pick_b, input int unsigned idx,
                                            input int unsigned n_small, input int unsigned n_mid,
                                            input int unsigned small_kb, input int unsigned mid_kb,
                                            input int unsigned big_kb);
    if (idx < n_small)                   return small_kb;
    if (!pick_b && idx < n_small + n_mid) return mid_kb;
    return big_kb;
  endfunction

endpackage

// File: rtl/fid_bus_seq.sv
module fid_bus_seq
  import fid_pkg::*;
#(
  parameter int FB_AW = 20,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             fb_ack,
  input  logic [DW-1:0]    fb_rdata,
  output logic             fb_wr,
  output logic             fb_rd,
  output logic [FB_AW-1:0] fb_addr,
  output logic [DW-1:0]    fb_wdata,
  output logic             seq_done,
  output logic [DW-1:0]    code_manuf,
  output logic [DW-1:0]    code_dev,
  output logic [DW-1:0]    code_ext
);

  localparam int NCODES = 3;

  logic              active_q;
  logic [STEP_W-1:0] step_q;
  logic              cur_rd;
  logic              acc_done;
  logic [DW-1:0]     code_q [NCODES];

  assign cur_rd   = step_is_read(step_q);
  assign fb_wr    = active_q & ~cur_rd;
  assign fb_rd    = active_q & cur_rd;
  assign fb_addr  = FB_AW'(step_addr(step_q));
  assign fb_wdata = DW'(step_data(step_q));
  assign acc_done = active_q & fb_ack;
  assign seq_done = acc_done && (step_q == STEP_W'(STEP_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      step_q   <= '0;
    end else if (acc_done) begin
      if (step_q == STEP_W'(STEP_LAST)) active_q <= 1'b0;
      else                              step_q   <= step_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[g] <= '0;
      else if (acc_done && cur_rd && read_slot(step_q) == 2'(g))
        code_q[g] <= fb_rdata;
    end
  end

  assign code_manuf = code_q[0];
  assign code_dev   = code_q[1];
  assign code_ext   = code_q[2];

  // R4: never a write and a read at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_wr && fb_rd));

  // R4: a pending access keeps its strobe, address and data until ready
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((fb_wr || fb_rd) && !fb_ack && !go) |=>
      ((fb_wr || fb_rd) && $stable(fb_addr) && $stable(fb_wdata) && $stable(fb_wr)));

  // R2: reads only ever target the low identification words
  a_r2_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd |-> (fb_addr < FB_AW'(4)));

endmodule

// File: rtl/fid_classify.sv
module fid_classify #(
  parameter int          DW        = 16,
  parameter int          CNT_W     = 6,
  parameter logic [15:0] VENDOR_ID = 16'h001F,
  parameter logic [15:0] DEV_B_ID  = 16'h00C0,
  parameter logic [15:0] EXT_B_ID  = 16'h00C8,
  parameter int          CNT_A     = 40,
  parameter int          CNT_B     = 39
) (
  input  logic [DW-1:0]    code_manuf,
  input  logic [DW-1:0]    code_dev,
  input  logic [DW-1:0]    code_ext,
  output logic             vendor_ok,
  output logic             pick_b,
  output logic [CNT_W-1:0] count
);

  assign vendor_ok = (code_manuf == DW'(VENDOR_ID));
  assign pick_b    = (code_dev == DW'(DEV_B_ID)) && (code_ext == DW'(EXT_B_ID));

  always_comb begin
    if (!vendor_ok)  count = '0;
    else if (pick_b) count = CNT_W'(CNT_B);
    else             count = CNT_W'(CNT_A);
  end

endmodule

// File: rtl/fid_sector_walk.sv
module fid_sector_walk
  import fid_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE = 32'h0100_0000,
  parameter int              CNT_W     = 6,
  parameter int              N_SMALL   = 8,
  parameter int              N_MID_A   = 2,
  parameter int              SMALL_KB  = 8,
  parameter int              MID_KB    = 32,
  parameter int              BIG_KB    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              pick_b,
  input  logic [CNT_W-1:0]  count,
  output logic              sec_valid,
  output logic [CNT_W-1:0]  sec_idx,
  output logic [ADDR_W-1:0] sec_addr,
  output logic              sec_last
);

  logic              active_q;
  logic [CNT_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] step_bytes;

  assign step_bytes = ADDR_W'(sector_kb(pick_b, int'(idx_q), N_SMALL, N_MID_A,
                                        SMALL_KB, MID_KB, BIG_KB)) << 10;

  assign sec_valid = active_q;
  assign sec_idx   = idx_q;
  assign sec_addr  = addr_q;
  assign sec_last  = active_q && (idx_q == count - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      addr_q   <= BANK_BASE;
    end else if (active_q) begin
      if (sec_last) active_q <= 1'b0;
      idx_q  <= idx_q + 1'b1;
      addr_q <= addr_q + step_bytes;
    end
  end

  // R8: the stream advances by one index per cycle without gaps
  a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && !sec_last) |=> (sec_valid && sec_idx == $past(sec_idx) + 1'b1));

  // R6: start addresses strictly rise through the bank
  a_r6_addr_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && !sec_last) |=> (sec_addr > $past(sec_addr)));

  // R8: the first entry after a launch is index 0 at the bank base
  a_r8_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_valid) |-> (sec_idx == '0 && sec_addr == BANK_BASE));

endmodule

// File: rtl/flash_id_mapper.sv
module flash_id_mapper
  import fid_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE = 32'h0100_0000,
  parameter int                FB_AW     = 20,
  parameter int                DW        = 16,
  parameter logic [15:0]       VENDOR_ID = 16'h001F,
  parameter logic [15:0]       DEV_B_ID  = 16'h00C0,
  parameter logic [15:0]       EXT_B_ID  = 16'h00C8,
  parameter int                N_SMALL   = 8,
  parameter int                N_MID_A   = 2,
  parameter int                N_BIG_A   = 30,
  parameter int                N_BIG_B   = 31,
  parameter int                SMALL_KB  = 8,
  parameter int                MID_KB    = 32,
  parameter int                BIG_KB    = 64,
  localparam int               CNT_A     = N_SMALL + N_MID_A + N_BIG_A,
  localparam int               CNT_B     = N_SMALL + N_BIG_B,
  localparam int               CNT_MAX   = (CNT_A > CNT_B) ? CNT_A : CNT_B,
  localparam int               CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              fb_wr,
  output logic              fb_rd,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [DW-1:0]     fb_wdata,
  input  logic [DW-1:0]     fb_rdata,
  input  logic              fb_ack,
  output logic              busy,
  output logic              done,
  output logic              unknown_vendor,
  output logic              org_b,
  output logic [CNT_W-1:0]  sector_count,
  output logic              sec_valid,
  output logic [CNT_W-1:0]  sec_idx,
  output logic [ADDR_W-1:0] sec_addr,
  output logic              sec_last
);

  fid_state_e        st_q;
  logic              go_seq;
  logic              seq_done;
  logic              go_walk;
  logic [DW-1:0]     code_manuf, code_dev, code_ext;
  logic              vendor_ok, pick_b;
  logic [CNT_W-1:0]  count_c;
  logic              org_b_q, unknown_q;
  logic [CNT_W-1:0]  count_q;

  assign go_seq  = start && (st_q == ST_IDLE);
  assign go_walk = (st_q == ST_CLASS) && vendor_ok;

  fid_bus_seq #(.FB_AW(FB_AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_seq),
    .fb_ack(fb_ack), .fb_rdata(fb_rdata),
    .fb_wr(fb_wr), .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .seq_done(seq_done),
    .code_manuf(code_manuf), .code_dev(code_dev), .code_ext(code_ext)
  );

  fid_classify #(
    .DW(DW), .CNT_W(CNT_W), .VENDOR_ID(VENDOR_ID), .DEV_B_ID(DEV_B_ID),
    .EXT_B_ID(EXT_B_ID), .CNT_A(CNT_A), .CNT_B(CNT_B)
  ) u_cls (
    .code_manuf(code_manuf), .code_dev(code_dev), .code_ext(code_ext),
    .vendor_ok(vendor_ok), .pick_b(pick_b), .count(count_c)
  );

  fid_sector_walk #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .CNT_W(CNT_W),
    .N_SMALL(N_SMALL), .N_MID_A(N_MID_A),
    .SMALL_KB(SMALL_KB), .MID_KB(MID_KB), .BIG_KB(BIG_KB)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go_walk),
    .pick_b(org_b_q), .count(count_q),
    .sec_valid(sec_valid), .sec_idx(sec_idx), .sec_addr(sec_addr), .sec_last(sec_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      org_b_q   <= 1'b0;
      unknown_q <= 1'b0;
      count_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (go_seq)   st_q <= ST_SEQ;
        ST_SEQ:   if (seq_done) st_q <= ST_CLASS;
        ST_CLASS: begin
          org_b_q   <= vendor_ok && pick_b;
          unknown_q <= !vendor_ok;
          count_q   <= count_c;
          st_q      <= vendor_ok ? ST_WALK : ST_FIN;
        end
        ST_WALK:  if (sec_last) st_q <= ST_FIN;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (st_q != ST_IDLE);
  assign done           = (st_q == ST_FIN);
  assign org_b          = org_b_q;
  assign unknown_vendor = unknown_q;
  assign sector_count   = count_q;

  // R10: an unknown part never produces a stream entry
  a_r10_silent: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_vendor |-> !sec_valid);

  // R9: results hold while idle and no start arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(org_b) && $stable(sector_count) && $stable(unknown_vendor)));

  // R11: done lasts one cycle and returns the block to idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6: the final entry carries the reported count minus one
  a_r6_last_index: assert property (@(posedge clk) disable iff (!rst_n)
    sec_last |-> (sec_idx == sector_count - 1'b1));

  // R4: no bus activity outside the command phase
  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SEQ) |-> !(fb_wr || fb_rd));

endmodule

// File: tb/flash_id_mapper_tb.sv
module flash_id_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fb_wr, fb_rd;
  logic [19:0] fb_addr;
  logic [15:0] fb_wdata;
  logic [15:0] fb_rdata = 16'h0;
  logic        fb_ack = 1'b0;
  logic        busy, done, unknown_vendor, org_b;
  logic [5:0]  sector_count;
  logic        sec_valid;
  logic [5:0]  sec_idx;
  logic [31:0] sec_addr;
  logic        sec_last;

  always #2.5 clk = ~clk;

  flash_id_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fb_wr(fb_wr), .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .fb_ack(fb_ack),
    .busy(busy), .done(done), .unknown_vendor(unknown_vendor), .org_b(org_b),
    .sector_count(sector_count), .sec_valid(sec_valid), .sec_idx(sec_idx),
    .sec_addr(sec_addr), .sec_last(sec_last)
  );

  int vectors = 0;
  int fails   = 0;

  // flash model state
  int          ack_delay = 0;
  int          wcnt = 0;
  logic [15:0] m_manuf = 16'h001F, m_dev = 16'h0, m_ext = 16'h0;
  logic        idm = 1'b0;
  logic [19:0] ha [3];
  logic [15:0] hd [3];
  int          log_n = 0;
  logic        log_rd   [16];
  logic [19:0] log_addr [16];
  logic [15:0] log_data [16];

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Flash responder, driven at the falling edge
  initial begin
    for (int i = 0; i < 3; i++) begin ha[i] = '0; hd[i] = '0; end
    forever begin
      @(negedge clk);
      if (fb_ack) begin
        fb_ack = 1'b0;
        wcnt = 0;
      end else if (fb_wr || fb_rd) begin
        if (wcnt >= ack_delay) begin
          fb_ack = 1'b1;
          wcnt = 0;
          if (log_n < 16) begin
            log_rd[log_n] = fb_rd; log_addr[log_n] = fb_addr; log_data[log_n] = fb_wdata;
          end
          log_n++;
          if (fb_wr) begin
            ha[0] = ha[1]; hd[0] = hd[1]; ha[1] = ha[2]; hd[1] = hd[2];
            ha[2] = fb_addr; hd[2] = fb_wdata;
            if (ha[0] == 20'h555 && hd[0] == 16'hAA && ha[1] == 20'hAAA && hd[1] == 16'h55 &&
                ha[2] == 20'h555) begin
              if (hd[2] == 16'h90) idm = 1'b1;
              if (hd[2] == 16'hF0) idm = 1'b0;
            end
          end else begin
            if (!idm)                    fb_rdata = 16'hFFFF;
            else if (fb_addr == 20'd0)   fb_rdata = m_manuf;
            else if (fb_addr == 20'd1)   fb_rdata = m_dev;
            else if (fb_addr == 20'd3)   fb_rdata = m_ext;
            else                         fb_rdata = 16'h0000;
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  // Expected start address: sum of region sizes below index n
  function automatic logic [31:0] exp_addr(input logic b, input int n);
    int kb = 0;
    for (int k = 0; k < n; k++) begin
      if (k < 8)             kb += 8;
      else if (!b && k < 10) kb += 32;
      else                   kb += 64;
    end
    return 32'h0100_0000 + 32'(kb) * 32'd1024;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_bus_log();
    logic [19:0] ea [9] = '{20'h555, 20'hAAA, 20'h555, 20'h0, 20'h1, 20'h3, 20'h555, 20'hAAA, 20'h555};
    logic [15:0] ed [9] = '{16'hAA, 16'h55, 16'h90, 16'h0, 16'h0, 16'h0, 16'hAA, 16'h55, 16'hF0};
    chk(log_n == 9, "R3 access count", log_n, 9);
    for (int i = 0; i < 9 && i < log_n; i++) begin
      logic isrd;
      isrd = (i >= 3 && i <= 5);
      if (isrd)
        chk(log_rd[i] && log_addr[i] == ea[i], "R2 read order", log_addr[i], ea[i]);
      else if (i < 3)
        chk(!log_rd[i] && log_addr[i] == ea[i] && log_data[i] == ed[i], "R1 entry write",
            {log_addr[i], log_data[i]}, {ea[i], ed[i]});
      else
        chk(!log_rd[i] && log_addr[i] == ea[i] && log_data[i] == ed[i], "R3 exit write",
            {log_addr[i], log_data[i]}, {ea[i], ed[i]});
    end
  endtask

  // Run one identification and check stream and results
  task automatic run_case(input string name, input logic [15:0] mf, input logic [15:0] dv,
                          input logic [15:0] ex, input int dly, input logic extra_start);
    logic exp_unk, exp_b;
    int   exp_cnt, n, cyc;
    logic started, gap;
    exp_unk = (mf != 16'h001F);
    exp_b   = !exp_unk && dv == 16'h00C0 && ex == 16'h00C8;
    exp_cnt = exp_unk ? 0 : (exp_b ? 39 : 40);
    m_manuf = mf; m_dev = dv; m_ext = ex; ack_delay = dly; log_n = 0;
    $display("-- %s", name);
    pulse_start();
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    n = 0; cyc = 0; started = 0; gap = 0;
    while (!done && cyc < 3000) begin
      if (extra_start && cyc == 4) begin start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (sec_valid) begin
        started = 1;
        chk(sec_idx == 6'(n), "R8 index", sec_idx, n);
        chk(sec_addr == exp_addr(exp_b, n), exp_b ? "R7 address" : "R6 address",
            sec_addr, exp_addr(exp_b, n));
        chk(sec_last == (n == exp_cnt - 1), "R8 last flag", sec_last, n == exp_cnt - 1);
        n++;
      end else if (started && n < exp_cnt) begin
        gap = 1;
      end
    end
    start = 1'b0;
    chk(done == 1'b1, "R11 done reached", done, 1);
    chk(!gap, "R8 no gap", gap, 0);
    chk(n == exp_cnt, exp_unk ? "R10 no stream" : (exp_b ? "R7 count" : "R6 count"), n, exp_cnt);
    chk(unknown_vendor == exp_unk, "R10 vendor flag", unknown_vendor, exp_unk);
    chk(org_b == exp_b, "R5 organization", org_b, exp_b);
    chk(sector_count == 6'(exp_cnt), "R9 sector_count", sector_count, exp_cnt);
    if (!exp_unk)
      chk(exp_addr(exp_b, exp_cnt) == 32'h0120_0000, "R6 bank fill", exp_addr(exp_b, exp_cnt), 32'h0120_0000);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 done one cycle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    check_bus_log();
  endtask

  task automatic test_reset();
    chk({fb_wr, fb_rd, busy, done, sec_valid, sec_last, org_b, unknown_vendor} == 8'h0,
        "R12 reset outputs", {fb_wr, fb_rd, busy, done, sec_valid, sec_last, org_b, unknown_vendor}, 0);
    chk(sector_count == 6'd0, "R12 reset count", sector_count, 0);
  endtask

  task automatic test_hold();
    logic b0; logic [5:0] c0;
    b0 = org_b; c0 = sector_count;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0)
        chk(org_b == b0 && sector_count == c0 && !sec_valid && !fb_wr && !fb_rd,
            "R9 hold while idle", {org_b, sector_count}, {b0, c0});
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case("R6 organization A", 16'h001F, 16'h00C4, 16'h0000, 0, 1'b0);
    run_case("R7 organization B", 16'h001F, 16'h00C0, 16'h00C8, 2, 1'b0);
    test_hold();
    run_case("R5 device match only", 16'h001F, 16'h00C0, 16'h00C9, 1, 1'b0);
    run_case("R5 extended match only", 16'h001F, 16'h00C1, 16'h00C8, 3, 1'b0);
    run_case("R10 foreign vendor", 16'h0020, 16'h00C0, 16'h00C8, 1, 1'b0);
    run_case("R11 start while busy", 16'h001F, 16'h00C0, 16'h00C8, 1, 1'b1);
    test_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule